// File: doc/BRIEF.md
# Vector Memory Address and Crossbar Unit

This unit sits between the lanes of a vector datapath and one shared data cache port. For each vector load or store it works out one byte address per element, queues those addresses, and sends them to the cache one at a time. On the way back, a read crossbar takes the word each element needs out of the returned cache line and hands it to the lane that owns the element. For stores, a write crossbar places the lane's store word and byte enables into the correct word slot of a cache-line-wide write.

An operation starts with a command: base address, stride, addressing mode, load or store, and vector length. The lanes then supply batches of `LANES` elements. Each batch carries a per-lane index, store word and byte enable. Element `e` belongs to lane `e mod LANES` and to batch `e / LANES`. Address generation for a whole batch happens in parallel, one adder path per lane. A batch is accepted only while the request queue has room, so a slow cache stalls the lanes. Once every element has been serviced, the unit raises a one-cycle completion pulse.

Top module: `vmu_top`

## Requirements
- R1: In mode code 0, and in mode code 3, element `e` gets the address `base + 4*e`.
- R2: In mode code 1, element `e` gets the address `base + stride*e` (32-bit wrap). `e` is the element number across the whole operation, so it keeps counting across batches.
- R3: In mode code 2, element `e = b*LANES + k` gets the address `base + index[k]`. Here `index[k]` is bits `[32k+31:32k]` of `bat_index` in batch `b`.
- R4: Only elements with `e < vlen` issue requests, so an operation issues exactly `vlen` requests. With `vlen = 0`, no request is issued and the operation still completes. No request is presented while the unit is idle.
- R5: Requests go out in ascending element order, at most one per cycle. While `mem_req_ready` is low, a presented request keeps its address and write flag unchanged. `mem_req_write` equals the command's store flag.
- R6: Each `mem_rsp_valid` cycle returns the line for the oldest outstanding load. Responses come back in order, in any cycle after the request was accepted. One cycle later, `rd_valid` pulses only on lane `e mod LANES`, and that lane's `rd_data` slice holds word `addr[2 +: log2(LINE_WORDS)]` of the line.
- R7: A store request puts the element's 32-bit word into word slot `w = addr[2 +: log2(LINE_WORDS)]` of `mem_req_wdata`. `mem_req_be` bits `[4w+3:4w]` carry the element's 4-bit byte enable, and all other enable bits are 0.
- R8: A batch is accepted (`bat_valid && bat_ready`) only while the request queue has room. If the cache accepts nothing, at most `QDEPTH+1` batches are taken, and then `bat_ready` stays low.
- R9: `cmd_ready` is high exactly when the unit is idle. Accepting a command sets `busy`. `done` is a single-cycle pulse, raised once all requests have been accepted and, for loads, all responses have been delivered. `busy` is low in the cycle of `done`.
- R10: After reset, `busy`, `done`, `mem_req_valid`, `bat_ready` and `rd_valid` are all 0, and `cmd_ready` is 1.
- R11: `bat_ready` falls once `ceil(vlen/LANES)` batches have been accepted for the current command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command taken |
| cmd_base | input | 32 | Base byte address |
| cmd_stride | input | 32 | Byte stride for mode 1 |
| cmd_mode | input | 2 | 0 unit, 1 strided, 2 indexed, 3 unit |
| cmd_store | input | 1 | 1 store, 0 load |
| cmd_vlen | input | clog2(MAX_VL+1) | Element count |
| bat_valid | input | 1 | Lane batch offered |
| bat_ready | output | 1 | Batch accepted this cycle |
| bat_index | input | LANES*32 | Per-lane byte offsets (mode 2) |
| bat_wdata | input | LANES*32 | Per-lane store words |
| bat_be | input | LANES*4 | Per-lane byte enables |
| mem_req_valid | output | 1 | Cache request valid |
| mem_req_ready | input | 1 | Cache accepts request |
| mem_req_addr | output | 32 | Element byte address |
| mem_req_write | output | 1 | Request is a store |
| mem_req_wdata | output | LINE_WORDS*32 | Line-wide store data |
| mem_req_be | output | LINE_WORDS*4 | Line-wide byte enables |
| mem_rsp_valid | input | 1 | Load line returned |
| mem_rsp_line | input | LINE_WORDS*32 | Returned cache line |
| rd_valid | output | LANES | Per-lane load data strobe |
| rd_data | output | LANES*32 | Per-lane load data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
The sweep crosses all four mode codes with loads and stores and with lengths of 0, 1, partial, one full batch, just over one batch and the maximum. These lengths separate the batch-boundary and tail-mask cases, and indexing by global element number from indexing by lane number. Negative and non-power-of-two strides, together with scattered indices, hit every word slot of a line, which exercises both crossbars at every offset. A cache that accepts every cycle, one that refuses every third cycle, and one that refuses until the queue fills each check request ordering, request holding and the queue-depth limit on batch acceptance.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  localparam int WORD_BITS = 32;
  localparam int BE_BITS   = WORD_BITS / 8;

  typedef enum logic [1:0] {
    AM_UNIT     = 2'd0,
    AM_STRIDE   = 2'd1,
    AM_INDEX    = 2'd2,
    AM_UNIT_ALT = 2'd3
  } amode_e;
endpackage

// File: rtl/vmu_fifo.sv
module vmu_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] ram [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) ram[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign dout  = ram[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  // R8
  fifo_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  // R6
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/vmu_agen.sv
module vmu_agen #(
  parameter int LANES = 4,
  parameter int VLW   = 5,
  parameter int BW    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [31:0]          base_i,
  input  logic [31:0]          stride_i,
  input  logic [1:0]           mode_i,
  input  logic [VLW-1:0]       vlen_i,
  input  logic                 take,
  input  logic [LANES*32-1:0]  index_i,
  output logic                 more,
  output logic [LANES*32-1:0]  addr_o,
  output logic [LANES-1:0]     mask_o
);
  import vmu_pkg::*;

  logic [31:0]    base_q, stride_q;
  amode_e         mode_q;
  logic [VLW-1:0] vlen_q;
  logic [BW-1:0]  bno_q, nbat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      stride_q <= '0;
      mode_q   <= AM_UNIT;
      vlen_q   <= '0;
      bno_q    <= '0;
      nbat_q   <= '0;
    end else if (start) begin
      base_q   <= base_i;
      stride_q <= stride_i;
      mode_q   <= amode_e'(mode_i);
      vlen_q   <= vlen_i;
      bno_q    <= '0;
      nbat_q   <= BW'((32'(vlen_i) + 32'(LANES) - 32'd1) / 32'(LANES));
    end else if (take) begin
      bno_q    <= bno_q + 1'b1;
    end
  end

  assign more = (bno_q != nbat_q);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [31:0] elem, off;
    assign elem = 32'(bno_q) * 32'(LANES) + 32'(k);
    always_comb begin
      case (mode_q)
        AM_STRIDE: off = stride_q * elem;
        AM_INDEX:  off = index_i[k*32 +: 32];
        default:   off = elem << 2;
      endcase
    end
    assign addr_o[k*32 +: 32] = base_q + off;
    assign mask_o[k]          = (elem < 32'(vlen_q));
  end
endmodule

// File: rtl/vmu_rd_xbar.sv
module vmu_rd_xbar #(
  parameter int LANES      = 4,
  parameter int LINE_WORDS = 4,
  parameter int LIDX       = 2,
  parameter int WSW        = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rsp_valid,
  input  logic [LINE_WORDS*32-1:0] line_i,
  input  logic [LIDX-1:0]          lane_i,
  input  logic [WSW-1:0]           wsel_i,
  output logic [LANES-1:0]         rd_valid,
  output logic [LANES*32-1:0]      rd_data
);
  logic [WSW-1:0] ws;
  logic [31:0]    word;

  assign ws   = (LINE_WORDS > 1) ? wsel_i : '0;
  assign word = line_i[32'(ws) * 32 +: 32];

  for (genvar k = 0; k < LANES; k++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_valid[k]          <= 1'b0;
        rd_data[k*32 +: 32]  <= '0;
      end else begin
        rd_valid[k] <= rsp_valid && (lane_i == LIDX'(k));
        if (rsp_valid && (lane_i == LIDX'(k))) rd_data[k*32 +: 32] <= word;
      end
    end
  end

  // R6
  rd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_valid));
  // R6
  rd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid != '0) |-> $past(rsp_valid));
endmodule

// File: rtl/vmu_wr_xbar.sv
module vmu_wr_xbar #(
  parameter int LINE_WORDS = 4,
  parameter int WSW        = 2
) (
  input  logic [31:0]              wdata_i,
  input  logic [3:0]               be_i,
  input  logic [WSW-1:0]           wsel_i,
  output logic [LINE_WORDS*32-1:0] line_wdata,
  output logic [LINE_WORDS*4-1:0]  line_be
);
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_slot
    logic hit;
    assign hit = (LINE_WORDS == 1) || (wsel_i == WSW'(w));
    assign line_wdata[w*32 +: 32] = hit ? wdata_i : '0;
    assign line_be[w*4 +: 4]      = hit ? be_i    : '0;
  end
endmodule

// File: rtl/vmu_top.sv
module vmu_top #(
  parameter int LANES      = 4,
  parameter int MAX_VL     = 16,
  parameter int LINE_WORDS = 4,
  parameter int QDEPTH     = 2,
  parameter int TDEPTH     = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cmd_valid,
  output logic                              cmd_ready,
  input  logic [31:0]                       cmd_base,
  input  logic [31:0]                       cmd_stride,
  input  logic [1:0]                        cmd_mode,
  input  logic                              cmd_store,
  input  logic [$clog2(MAX_VL+1)-1:0]       cmd_vlen,
  input  logic                              bat_valid,
  output logic                              bat_ready,
  input  logic [LANES*32-1:0]               bat_index,
  input  logic [LANES*32-1:0]               bat_wdata,
  input  logic [LANES*4-1:0]                bat_be,
  output logic                              mem_req_valid,
  input  logic                              mem_req_ready,
  output logic [31:0]                       mem_req_addr,
  output logic                              mem_req_write,
  output logic [LINE_WORDS*32-1:0]          mem_req_wdata,
  output logic [LINE_WORDS*4-1:0]           mem_req_be,
  input  logic                              mem_rsp_valid,
  input  logic [LINE_WORDS*32-1:0]          mem_rsp_line,
  output logic [LANES-1:0]                  rd_valid,
  output logic [LANES*32-1:0]               rd_data,
  output logic                              busy,
  output logic                              done
);
  localparam int VLW  = $clog2(MAX_VL + 1);
  localparam int MAXB = (MAX_VL + LANES - 1) / LANES;
  localparam int BW   = $clog2(MAXB + 1);
  localparam int LIDX = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int WSW  = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
  localparam int QW   = LANES * (32 + 32 + 4 + 1);
  localparam int TW   = LIDX + WSW;

  // batch generation
  logic                more;
  logic [LANES*32-1:0] gen_addr;
  logic [LANES-1:0]    gen_mask;
  logic                cmd_take, bat_take;

  assign cmd_ready = !busy;
  assign cmd_take  = cmd_valid && cmd_ready;

  vmu_agen #(.LANES(LANES), .VLW(VLW), .BW(BW)) u_agen (
    .clk(clk), .rst(rst), .start(cmd_take),
    .base_i(cmd_base), .stride_i(cmd_stride), .mode_i(cmd_mode), .vlen_i(cmd_vlen),
    .take(bat_take), .index_i(bat_index),
    .more(more), .addr_o(gen_addr), .mask_o(gen_mask)
  );

  // request queue of whole batches
  logic          q_full, q_empty, q_pop;
  logic [QW-1:0] q_dout;
  logic [LANES*32-1:0] q_addr, q_wdata;
  logic [LANES*4-1:0]  q_be;
  logic [LANES-1:0]    q_mask;

  assign bat_ready = busy && more && !q_full;
  assign bat_take  = bat_valid && bat_ready;

  vmu_fifo #(.WIDTH(QW), .DEPTH(QDEPTH)) u_reqq (
    .clk(clk), .rst(rst), .push(bat_take),
    .din({gen_addr, bat_wdata, bat_be, gen_mask}),
    .pop(q_pop), .dout(q_dout), .full(q_full), .empty(q_empty)
  );
  assign {q_addr, q_wdata, q_be, q_mask} = q_dout;

  // serializer onto the shared cache port
  logic                cur_v, store_q;
  logic [LANES-1:0]    cur_left, left_nx;
  logic [LANES*32-1:0] cur_addr, cur_wdata;
  logic [LANES*4-1:0]  cur_be;
  logic [LIDX-1:0]     sel;
  logic [WSW-1:0]      wsel;
  logic                tag_full, tag_empty, tag_push, req_fire, all_clear;
  logic [TW-1:0]       tag_dout;

  always_comb begin
    sel = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (cur_left[k]) sel = LIDX'(k);
    end
  end

  assign left_nx       = cur_left & ~(LANES'(1) << sel);
  assign mem_req_addr  = cur_addr[32'(sel) * 32 +: 32];
  assign wsel          = WSW'(mem_req_addr[31:2] & 30'(LINE_WORDS - 1));
  assign mem_req_valid = cur_v && (store_q || !tag_full);
  assign mem_req_write = store_q;
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign q_pop         = !cur_v && !q_empty;
  assign tag_push      = req_fire && !store_q;
  assign all_clear     = !more && q_empty && !cur_v && tag_empty;

  vmu_wr_xbar #(.LINE_WORDS(LINE_WORDS), .WSW(WSW)) u_wxbar (
    .wdata_i(cur_wdata[32'(sel) * 32 +: 32]), .be_i(cur_be[32'(sel) * 4 +: 4]),
    .wsel_i(wsel), .line_wdata(mem_req_wdata), .line_be(mem_req_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      store_q  <= 1'b0;
      cur_v    <= 1'b0;
      cur_left <= '0;
    end else begin
      done <= 1'b0;
      if (cmd_take) begin
        busy    <= 1'b1;
        store_q <= cmd_store;
      end else if (busy && all_clear) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      if (q_pop) begin
        cur_v    <= 1'b1;
        cur_left <= q_mask;
      end else if (req_fire) begin
        cur_left <= left_nx;
        if (left_nx == '0) cur_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (q_pop) begin
      cur_addr  <= q_addr;
      cur_wdata <= q_wdata;
      cur_be    <= q_be;
    end
  end

  // outstanding load tags and read crossbar
  vmu_fifo #(.WIDTH(TW), .DEPTH(TDEPTH)) u_tagq (
    .clk(clk), .rst(rst), .push(tag_push), .din({sel, wsel}),
    .pop(mem_rsp_valid), .dout(tag_dout), .full(tag_full), .empty(tag_empty)
  );

  vmu_rd_xbar #(.LANES(LANES), .LINE_WORDS(LINE_WORDS), .LIDX(LIDX), .WSW(WSW)) u_rxbar (
    .clk(clk), .rst(rst), .rsp_valid(mem_rsp_valid), .line_i(mem_rsp_line),
    .lane_i(tag_dout[TW-1 -: LIDX]), .wsel_i(tag_dout[WSW-1:0]),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
  // R4
  no_req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req_valid));
  // R6
  rsp_tag_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> !tag_empty);
endmodule

// File: tb/test_vmu_top.sv
module test_vmu_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int MAX_VL     = 16;
  localparam int LINE_WORDS = 4;
  localparam int QDEPTH     = 2;
  localparam int VLW        = $clog2(MAX_VL + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_base = '0, cmd_stride = '0;
  logic [1:0]  cmd_mode = '0;
  logic cmd_store = 1'b0;
  logic [VLW-1:0] cmd_vlen = '0;
  logic bat_valid = 1'b0, bat_ready;
  logic [LANES*32-1:0] bat_index = '0, bat_wdata = '0;
  logic [LANES*4-1:0]  bat_be = '0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [31:0] mem_req_addr;
  logic [LINE_WORDS*32-1:0] mem_req_wdata, mem_rsp_line = '0;
  logic [LINE_WORDS*4-1:0]  mem_req_be;
  logic mem_rsp_valid = 1'b0;
  logic [LANES-1:0] rd_valid;
  logic [LANES*32-1:0] rd_data;
  logic busy, done;

  vmu_top #(.LANES(LANES), .MAX_VL(MAX_VL), .LINE_WORDS(LINE_WORDS),
            .QDEPTH(QDEPTH), .TDEPTH(4)) i_vmu_top (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_mode(cmd_mode),
    .cmd_store(cmd_store), .cmd_vlen(cmd_vlen), .bat_valid(bat_valid),
    .bat_ready(bat_ready), .bat_index(bat_index), .bat_wdata(bat_wdata),
    .bat_be(bat_be), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_write(mem_req_write),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mem [64];
  int cyc = 0, opn = 0;
  int g_mode = 0, g_vlen = 0, rmode = 0;
  bit g_store = 0;
  logic [31:0] g_base = '0, g_stride = '0;
  int req_cnt = 0, done_cnt = 0;
  logic [LINE_WORDS*32-1:0] pl [16];
  int pe [16], pt [16];
  int pw = 0, pr = 0;
  bit rd_exp = 0;
  int rd_e = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (op %0d)", req, act, exp, opn);
    end
  endtask

  function automatic logic [31:0] idx_of(input int e);
    return 32'(((e * 5 + 9) % 64) * 4);
  endfunction
  function automatic logic [31:0] wd_of(input int e);
    return 32'hC0DE0000 ^ (32'(e) * 32'h01010101) ^ (32'(opn) << 12);
  endfunction
  function automatic logic [3:0] be_of(input int e);
    return 4'((e % 15) + 1);
  endfunction
  function automatic logic [31:0] exp_addr(input int e);
    case (g_mode)
      1:       return g_base + g_stride * 32'(e);
      2:       return g_base + idx_of(e);
      default: return g_base + 32'(e) * 4;
    endcase
  endfunction

  // cache model and output monitor
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + 32'(i) * 32'h0001_0207;
    forever begin
      int ne;
      ne = 0;
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pr != pw && cyc >= pt[pr % 16] + 2) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_line  = pl[pr % 16];
        ne = pe[pr % 16];
        pr++;
      end
      mem_req_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 0) : 1'b0;
      #1;
      if (!rst) begin
        if (rd_exp) begin
          logic [31:0] a;
          int ln;
          ln = rd_e % LANES;
          a = exp_addr(rd_e);
          chk(rd_valid == LANES'(1 << ln), "R6 lane strobe", 64'(rd_valid), 64'(1 << ln));
          chk(rd_data[ln*32 +: 32] == mem[a[7:2]], "R6 word select",
              64'(rd_data[ln*32 +: 32]), 64'(mem[a[7:2]]));
        end else if (rd_valid != '0) begin
          chk(1'b0, "R6 spurious strobe", 64'(rd_valid), 64'd0);
        end
        rd_exp = mem_rsp_valid;
        rd_e   = ne;
        if (done) done_cnt++;
        if (mem_req_valid && mem_req_ready) begin
          logic [31:0] a, wdv;
          logic [3:0] bev;
          logic [LINE_WORDS*4-1:0] ebe;
          int wi, slot;
          string tag;
          a    = exp_addr(req_cnt);
          wi   = int'(a[7:2]);
          slot = int'(a[3:2]);
          tag  = (g_mode == 1) ? "R2 strided addr" : (g_mode == 2) ? "R3 indexed addr" : "R1 unit addr";
          chk(req_cnt < g_vlen, "R4 extra request", 64'(req_cnt), 64'(g_vlen));
          chk(mem_req_addr == a, tag, 64'(mem_req_addr), 64'(a));
          chk(mem_req_write == g_store, "R5 write flag", 64'(mem_req_write), 64'(g_store));
          if (g_store) begin
            wdv = wd_of(req_cnt);
            bev = be_of(req_cnt);
            ebe = (LINE_WORDS*4)'(bev) << (slot * 4);
            chk(mem_req_be == ebe, "R7 byte enables", 64'(mem_req_be), 64'(ebe));
            chk(mem_req_wdata[slot*32 +: 32] == wdv, "R7 write slot",
                64'(mem_req_wdata[slot*32 +: 32]), 64'(wdv));
            for (int b = 0; b < 4; b++) if (bev[b]) mem[wi][b*8 +: 8] = wdv[b*8 +: 8];
          end else begin
            for (int w = 0; w < LINE_WORDS; w++) pl[pw % 16][w*32 +: 32] = mem[(wi & ~3) + w];
            pe[pw % 16] = req_cnt;
            pt[pw % 16] = cyc;
            pw++;
          end
          req_cnt++;
        end
      end
    end
  end

  task automatic set_batch(input int b);
    for (int k = 0; k < LANES; k++) begin
      bat_index[k*32 +: 32] = idx_of(b * LANES + k);
      bat_wdata[k*32 +: 32] = wd_of(b * LANES + k);
      bat_be[k*4 +: 4]      = be_of(b * LANES + k);
    end
  endtask

  task automatic run_op(input int mode, input bit st, input logic [31:0] base,
                        input logic [31:0] stride, input int vlen, input int rm, input bit stall);
    int nb, b, d0, t;
    opn++;
    g_mode = mode; g_store = st; g_base = base; g_stride = stride; g_vlen = vlen;
    req_cnt = 0;
    d0 = done_cnt;
    nb = (vlen + LANES - 1) / LANES;
    rmode = stall ? 2 : rm;
    @(negedge clk); #2;
    chk(cmd_ready == 1'b1 && busy == 1'b0, "R9 idle before command", 64'({cmd_ready, busy}), 64'b10);
    cmd_valid = 1'b1; cmd_base = base; cmd_stride = stride;
    cmd_mode = 2'(mode); cmd_store = st; cmd_vlen = VLW'(vlen);
    @(negedge clk);
    cmd_valid = 1'b0;
    b = 0;
    if (stall) begin
      for (int c = 0; c < 12; c++) begin
        if (b < nb) begin set_batch(b); bat_valid = 1'b1; end
        #2;
        if (bat_valid && bat_ready) b++;
        @(negedge clk);
      end
      #2;
      chk(b == QDEPTH + 1, "R8 batches taken while cache stalled", 64'(b), 64'(QDEPTH + 1));
      chk(bat_ready == 1'b0, "R8 input stalled", 64'(bat_ready), 64'd0);
      rmode = rm;
      @(negedge clk);
    end
    while (b < nb) begin
      set_batch(b);
      bat_valid = 1'b1;
      #2;
      if (bat_ready) b++;
      @(negedge clk);
    end
    bat_valid = 1'b0;
    #2;
    chk(bat_ready == 1'b0, "R11 no batch after last", 64'(bat_ready), 64'd0);
    t = 0;
    while (done_cnt == d0 && t < 3000) begin
      @(negedge clk); #2;
      t++;
    end
    chk(done_cnt == d0 + 1, "R9 completion pulse", 64'(done_cnt - d0), 64'd1);
    chk(req_cnt == vlen, "R4 request count", 64'(req_cnt), 64'(vlen));
    chk(busy == 1'b0 && cmd_ready == 1'b1, "R9 idle at done", 64'({busy, cmd_ready}), 64'b01);
    if (!st) chk(pr == pw, "R6 all loads returned", 64'(pw - pr), 64'd0);
    @(negedge clk); #2;
    chk(done == 1'b0, "R9 single-cycle done", 64'(done), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int vls [6];
    logic [31:0] strides [3];
    vls[0] = 0; vls[1] = 1; vls[2] = 3; vls[3] = 4; vls[4] = 5; vls[5] = 16;
    strides[0] = 32'd8; strides[1] = 32'hFFFF_FFF4; strides[2] = 32'd20;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(busy == 0 && done == 0 && mem_req_valid == 0 && bat_ready == 0 && rd_valid == '0,
        "R10 reset outputs", 64'({busy, done, mem_req_valid, bat_ready, rd_valid}), 64'd0);
    chk(cmd_ready == 1'b1, "R10 ready after reset", 64'(cmd_ready), 64'd1);
    @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < 4; m++) begin
      for (int s = 1; s >= 0; s--) begin
        for (int v = 0; v < 6; v++) begin
          run_op(m, s[0], 32'h0000_0100 * 32'(m) + 32'(4 * v), strides[v % 3],
                 vls[v], (v + m) % 2, 1'b0);
        end
      end
    end
    run_op(0, 1'b0, 32'h40, 32'd0, 16, 0, 1'b1);
    run_op(1, 1'b1, 32'h80, 32'd12, 16, 1, 1'b1);
    run_op(1, 1'b0, 32'h80, 32'd12, 16, 0, 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule